// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block handles even parity for a 32-bit multiplexed address/data bus with four command/byte-enable lines. Each clock it folds the 36 bus bits into one parity bit and registers it, so the parity output always trails the bus by exactly one clock. Its output enable is also registered. It opens only when the local agent drove the address/data lines in the previous clock, and only in the right role: it initiated the transaction during an address phase, or during a data phase it was the initiator of a write or the target of a read.

When the local agent is the target of a write, every data phase in which both ready strobes are low is captured. The parity line is sampled on the next clock and compared with the captured bits. On a mismatch the block drives the low-active error line for one clock, two clocks after the failing data phase, if a response-enable input allows it. It also sets a sticky status bit and pulses one of two interrupt requests. A configuration input chooses which request. The same request pulse follows an error line pulled low by another device.

Top module: `pci_parity_unit`

## Requirements
- R1: One clock after any cycle, `par_o` equals the XOR of all 36 bits `{ad_i, cbe_i}` of that cycle, whatever the byte-enable values, so the 36 bits plus `par_o` hold an even number of ones.
- R2: After an address-phase cycle (`addr_phase_i`=1), `par_oe_o` is 1 in the next clock if and only if `ad_oe_i`=1 and `is_init_i`=1.
- R3: After a data-phase cycle (`addr_phase_i`=0), `par_oe_o` is 1 in the next clock if and only if `ad_oe_i`=1 and either (`is_init_i`=1, `is_write_i`=1) or (`is_init_i`=0, `is_write_i`=0).
- R4: While `rst_ni` is low: `par_o`=0, `par_oe_o`=0, `perr_n_o`=1, `perr_oe_o`=0, `par_err_sts_o`=0, `nmi_o`=0, `smi_o`=0.
- R5: A parity check is made only for a cycle with `addr_phase_i`=0, `irdy_n_i`=0, `trdy_n_i`=0, `is_init_i`=0 and `is_write_i`=1. The check compares `par_i` of the following cycle with that cycle's 36 bits. A mismatch sets `par_err_sts_o` two clocks after the data phase. Any other cycle type never reports an error.
- R6: On a detected mismatch with `perr_resp_en_i`=1, `perr_n_o`=0 and `perr_oe_o`=1 for exactly one clock, two clocks after the failing data phase. With `perr_resp_en_i`=0 they stay at 1 and 0, and status and request still happen.
- R7: `par_err_sts_o` stays set until a cycle with `status_clr_i`=1. A new error in that same clock wins over the clear.
- R8: A detected mismatch pulses `nmi_o` for one clock when `err_sel_smi_i`=0, and `smi_o` when `err_sel_smi_i`=1, in the same clock as the `perr_n_o` pulse. Both are never high together.
- R9: `perr_n_i`=0 while `perr_oe_o`=0 pulses the selected request output (the R8 encoding) in the next clock.
- R10: When `par_i` matches, a checked data phase changes neither `perr_n_o`, `par_err_sts_o`, `nmi_o` nor `smi_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ad_i | input | 32 | Address/data value on the bus this cycle |
| cbe_i | input | 4 | Command/byte-enable value on the bus this cycle |
| ad_oe_i | input | 1 | Local agent drives the address/data lines this cycle |
| addr_phase_i | input | 1 | 1: address phase, 0: data phase |
| irdy_n_i | input | 1 | Initiator ready, active low |
| trdy_n_i | input | 1 | Target ready, active low |
| is_init_i | input | 1 | 1: local agent is initiator, 0: target |
| is_write_i | input | 1 | 1: write transaction, 0: read |
| par_i | input | 1 | Parity line sampled from the bus |
| perr_n_i | input | 1 | Error line sampled from the bus, active low |
| perr_resp_en_i | input | 1 | Allows driving the error line |
| err_sel_smi_i | input | 1 | Request routing: 0 to nmi_o, 1 to smi_o |
| status_clr_i | input | 1 | Write-one-to-clear pulse for the status bit |
| par_o | output | 1 | Registered parity value |
| par_oe_o | output | 1 | Parity output enable |
| perr_n_o | output | 1 | Error line value, active low |
| perr_oe_o | output | 1 | Error line output enable |
| par_err_sts_o | output | 1 | Sticky detected-parity-error status |
| nmi_o | output | 1 | Non-maskable request pulse |
| smi_o | output | 1 | Management request pulse |

## Verification
The bench walks single set bits through all 36 positions and a batch of mixed words. A parity tree that dropped the byte-enable lines or a bit would give a wrong `par_o`. It sweeps all 32 combinations of phase, role, direction and the two ready strobes with corrupted parity. A checker that ignored one of these qualifiers would fire on a phase it must skip or miss the one it must catch. Each error is timed to the exact clock, which catches a pipeline one stage short or long. The same clock also checks the response enable, the request routing, and a clear landing in the same clock as a new error: a clear given priority would lose that error.

// File: rtl/pci_par_pkg.sv
`timescale 1ns/1ps
package pci_par_pkg;
  typedef enum logic {
    ROUTE_NMI = 1'b0,
    ROUTE_SMI = 1'b1
  } err_route_e;

  typedef struct packed {
    logic addr;
    logic init;
    logic write;
    logic xfer;
  } phase_t;

  // data-phase drive rule: initiator of a write or target of a read
  function automatic logic drives_data(input phase_t p);
    return p.init == p.write;
  endfunction
endpackage

// File: rtl/pci_par_tree.sv
`timescale 1ns/1ps
module pci_par_tree #(
  parameter int W = 36
) (
  input  logic [W-1:0] data_i,
  output logic         par_o
);
  localparam int LVL = (W > 1) ? $clog2(W) : 1;
  localparam int N   = 1 << LVL;

  logic [N-1:0] leaf;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_leaf
      if (gi < W) begin : g_bit
        assign leaf[gi] = data_i[gi];
      end else begin : g_pad
        assign leaf[gi] = 1'b0;
      end
    end
  endgenerate

  // balanced fold, depth LVL
  always_comb begin
    logic [N-1:0] t;
    t = leaf;
    for (int s = N / 2; s >= 1; s = s / 2) begin
      for (int i = 0; i < s; i++) begin
        t[i] = t[2*i] ^ t[2*i+1];
      end
    end
    par_o = t[0];
  end
endmodule

// File: rtl/pci_par_drive.sv
`timescale 1ns/1ps
module pci_par_drive
  import pci_par_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   par_calc_i,
  input  logic   ad_oe_i,
  input  phase_t phase_i,
  output logic   par_o,
  output logic   par_oe_o
);
  logic role_ok;

  always_comb begin
    if (phase_i.addr) role_ok = phase_i.init;
    else              role_ok = drives_data(phase_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_o    <= 1'b0;
      par_oe_o <= 1'b0;
    end else begin
      par_o    <= par_calc_i;
      par_oe_o <= ad_oe_i & role_ok;
    end
  end
endmodule

// File: rtl/pci_par_check.sv
`timescale 1ns/1ps
module pci_par_check
  import pci_par_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   par_calc_i,
  input  phase_t phase_i,
  input  logic   par_bus_i,
  output logic   det_o
);
  logic chk_now;
  logic cap_vld_q;
  logic cap_par_q;

  assign chk_now = !phase_i.addr & phase_i.xfer & !phase_i.init & phase_i.write;

  // stage 1: capture phase parity; stage 2: compare with delayed bus parity
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_vld_q <= 1'b0;
      cap_par_q <= 1'b0;
      det_o     <= 1'b0;
    end else begin
      cap_vld_q <= chk_now;
      cap_par_q <= par_calc_i;
      det_o     <= cap_vld_q & (par_bus_i != cap_par_q);
    end
  end
endmodule

// File: rtl/pci_par_report.sv
`timescale 1ns/1ps
module pci_par_report
  import pci_par_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       det_i,
  input  logic       perr_bus_n_i,
  input  logic       resp_en_i,
  input  err_route_e route_i,
  input  logic       clr_i,
  output logic       perr_n_o,
  output logic       perr_oe_o,
  output logic       sts_o,
  output logic       nmi_o,
  output logic       smi_o
);
  logic drive;
  logic ext_err;
  logic evt;

  assign drive   = det_i & resp_en_i;
  // ignore our own pulse seen back on the wire
  assign ext_err = !perr_bus_n_i & !perr_oe_o;
  assign evt     = det_i | ext_err;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      perr_n_o  <= 1'b1;
      perr_oe_o <= 1'b0;
      sts_o     <= 1'b0;
      nmi_o     <= 1'b0;
      smi_o     <= 1'b0;
    end else begin
      perr_n_o  <= !drive;
      perr_oe_o <= drive;
      sts_o     <= det_i | (sts_o & !clr_i);
      nmi_o     <= evt & (route_i == ROUTE_NMI);
      smi_o     <= evt & (route_i == ROUTE_SMI);
    end
  end
endmodule

// File: rtl/pci_parity_unit.sv
`timescale 1ns/1ps
module pci_parity_unit
  import pci_par_pkg::*;
#(
  parameter int AD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AD_W-1:0]   ad_i,
  input  logic [AD_W/8-1:0] cbe_i,
  input  logic              ad_oe_i,
  input  logic              addr_phase_i,
  input  logic              irdy_n_i,
  input  logic              trdy_n_i,
  input  logic              is_init_i,
  input  logic              is_write_i,
  input  logic              par_i,
  input  logic              perr_n_i,
  input  logic              perr_resp_en_i,
  input  logic              err_sel_smi_i,
  input  logic              status_clr_i,
  output logic              par_o,
  output logic              par_oe_o,
  output logic              perr_n_o,
  output logic              perr_oe_o,
  output logic              par_err_sts_o,
  output logic              nmi_o,
  output logic              smi_o
);
  localparam int BE_W  = AD_W / 8;
  localparam int TOT_W = AD_W + BE_W;

  phase_t     phase;
  logic       par_calc;
  logic       det;
  err_route_e route;

  assign phase.addr  = addr_phase_i;
  assign phase.init  = is_init_i;
  assign phase.write = is_write_i;
  assign phase.xfer  = !irdy_n_i & !trdy_n_i;
  assign route       = err_route_e'(err_sel_smi_i);

  // one tree shared by drive and check paths
  pci_par_tree #(.W(TOT_W)) u_tree (
    .data_i ({ad_i, cbe_i}),
    .par_o  (par_calc)
  );

  pci_par_drive u_drive (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .par_calc_i (par_calc),
    .ad_oe_i    (ad_oe_i),
    .phase_i    (phase),
    .par_o      (par_o),
    .par_oe_o   (par_oe_o)
  );

  pci_par_check u_check (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .par_calc_i (par_calc),
    .phase_i    (phase),
    .par_bus_i  (par_i),
    .det_o      (det)
  );

  pci_par_report u_report (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .det_i        (det),
    .perr_bus_n_i (perr_n_i),
    .resp_en_i    (perr_resp_en_i),
    .route_i      (route),
    .clr_i        (status_clr_i),
    .perr_n_o     (perr_n_o),
    .perr_oe_o    (perr_oe_o),
    .sts_o        (par_err_sts_o),
    .nmi_o        (nmi_o),
    .smi_o        (smi_o)
  );
endmodule

// File: rtl/pci_parity_unit_chk.sv
`timescale 1ns/1ps
module pci_parity_unit_chk #(
  parameter int AD_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [AD_W-1:0]   ad_i,
  input logic [AD_W/8-1:0] cbe_i,
  input logic              ad_oe_i,
  input logic              addr_phase_i,
  input logic              is_init_i,
  input logic              perr_resp_en_i,
  input logic              err_sel_smi_i,
  input logic              status_clr_i,
  input logic              par_o,
  input logic              par_oe_o,
  input logic              perr_n_o,
  input logic              par_err_sts_o,
  input logic              nmi_o,
  input logic              smi_o
);
  p_par_even_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (par_o == ^{$past(ad_i), $past(cbe_i)}));

  p_addr_drive_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_phase_i && ad_oe_i && is_init_i) |=> par_oe_o);

  p_addr_target_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_phase_i && !is_init_i) |=> !par_oe_o);

  p_data_no_oe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!addr_phase_i && !ad_oe_i) |=> !par_oe_o);

  p_perr_sets_sts_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !perr_n_o |-> par_err_sts_o);

  p_perr_gated_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !perr_n_o |-> $past(perr_resp_en_i));

  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_err_sts_o && !status_clr_i) |=> par_err_sts_o);

  p_one_route_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nmi_o && smi_o));

  p_nmi_route_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |-> !$past(err_sel_smi_i));
endmodule

bind pci_parity_unit pci_parity_unit_chk #(.AD_W(AD_W)) u_chk (.*);

// File: tb/pci_parity_unit_test.sv
`timescale 1ns/1ps
module pci_parity_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] ad_i = '0;
  logic [3:0]  cbe_i = '0;
  logic        ad_oe_i = 0, addr_phase_i = 0, irdy_n_i = 1, trdy_n_i = 1;
  logic        is_init_i = 0, is_write_i = 0, par_i = 0, perr_n_i = 1;
  logic        perr_resp_en_i = 1, err_sel_smi_i = 0, status_clr_i = 0;
  logic        par_o, par_oe_o, perr_n_o, perr_oe_o, par_err_sts_o, nmi_o, smi_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  pci_parity_unit uut (.*);

  task automatic chk(input string r, input logic [63:0] a, input logic [63:0] e);
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, a, e);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic idle();
    ad_oe_i = 0; addr_phase_i = 0; irdy_n_i = 1; trdy_n_i = 1;
    is_init_i = 0; is_write_i = 0; perr_n_i = 1; status_clr_i = 0;
  endtask

  task automatic clear_sts();
    status_clr_i = 1;
    tick();
    status_clr_i = 0;
    chk("R7 clear", par_err_sts_o, 0);
  endtask

  // one phase, then corrupted/correct par_i, then watch error timing
  task automatic run_phase(input bit a, input bit ini, input bit wr, input bit irn,
                           input bit trn, input bit corrupt, input bit en, input bit sel,
                           input logic [31:0] d, input logic [3:0] c);
    bit exp_err;
    bit good;
    exp_err = !a && !ini && wr && !irn && !trn && corrupt;
    good = ($countones({d, c}) % 2) == 1;
    perr_resp_en_i = en; err_sel_smi_i = sel;
    addr_phase_i = a; is_init_i = ini; is_write_i = wr; irdy_n_i = irn; trdy_n_i = trn;
    ad_i = d; cbe_i = c;
    tick();
    idle();
    par_i = corrupt ? !good : good;
    tick();
    chk("R6 early", perr_n_o, 1);
    chk("R5 early", par_err_sts_o, 0);
    par_i = 0;
    tick();
    chk("R6 perr", perr_n_o, !(exp_err && en));
    chk("R6 perr_oe", perr_oe_o, exp_err && en);
    chk("R5 status", par_err_sts_o, exp_err);
    chk("R8 nmi", nmi_o, exp_err && !sel);
    chk("R8 smi", smi_o, exp_err && sel);
    tick();
    chk("R6 one clock", perr_n_o, 1);
    chk("R8 pulse end", nmi_o | smi_o, 0);
    chk("R7 sticky", par_err_sts_o, exp_err);
    clear_sts();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    ad_i = 32'hFFFF_FFFF; cbe_i = 4'h7; ad_oe_i = 1; is_init_i = 1; addr_phase_i = 1;
    repeat (3) @(negedge clk_i);
    chk("R4 par", par_o, 0);
    chk("R4 par_oe", par_oe_o, 0);
    chk("R4 perr", perr_n_o, 1);
    chk("R4 perr_oe", perr_oe_o, 0);
    chk("R4 sts", par_err_sts_o, 0);
    chk("R4 req", {nmi_o, smi_o}, 0);
    idle();
    rst_ni = 1;
    tick();

    // R1: walking single ones, then mixed words
    for (int b = 0; b < 36; b++) begin
      {ad_i, cbe_i} = 36'd1 << b;
      tick();
      chk("R1 walk", par_o, 1);
    end
    for (int k = 0; k < 64; k++) begin
      logic [31:0] v;
      v = k * 32'h9E37_79B9 + 32'h1234_5678;
      ad_i = v; cbe_i = k[3:0];
      tick();
      chk("R1 mix", par_o, $countones({v, k[3:0]}) % 2);
    end

    // R2/R3: role, phase, direction, output enable sweep
    for (int m = 0; m < 16; m++) begin
      bit e;
      addr_phase_i = m[0]; is_init_i = m[1]; is_write_i = m[2]; ad_oe_i = m[3];
      e = m[3] && (m[0] ? m[1] : (m[1] == m[2]));
      tick();
      chk(m[0] ? "R2 par_oe" : "R3 par_oe", par_oe_o, e);
    end
    idle();
    tick();

    // R5: qualifier sweep with corrupted parity
    for (int m = 0; m < 32; m++)
      run_phase(m[0], m[1], m[2], m[3], m[4], 1, 1, 0, 32'hA5C3_0F1E + m, m[3:0]);

    run_phase(0, 0, 1, 0, 0, 0, 1, 0, 32'hDEAD_BEEF, 4'hC);  // R10 good parity
    run_phase(0, 0, 1, 0, 0, 0, 1, 1, 32'h0000_0001, 4'h0);  // R10
    run_phase(0, 0, 1, 0, 0, 1, 0, 0, 32'h1357_9BDF, 4'h3);  // R6 response disabled
    run_phase(0, 0, 1, 0, 0, 1, 1, 1, 32'h8000_0000, 4'hF);  // R8 smi route

    // R7: error and clear in the same clock, then long hold
    perr_resp_en_i = 1; err_sel_smi_i = 0;
    is_write_i = 1; irdy_n_i = 0; trdy_n_i = 0; ad_i = 0; cbe_i = 0;
    tick();
    idle();
    par_i = 1;
    tick();
    status_clr_i = 1;
    tick();
    status_clr_i = 0;
    chk("R7 set wins", par_err_sts_o, 1);
    repeat (5) tick();
    chk("R7 hold", par_err_sts_o, 1);
    clear_sts();
    par_i = 0;

    // R9: external error line
    for (int s = 0; s < 2; s++) begin
      err_sel_smi_i = s[0];
      perr_n_i = 0;
      tick();
      perr_n_i = 1;
      chk("R9 nmi", nmi_o, !s[0]);
      chk("R9 smi", smi_o, s[0]);
      chk("R9 no status", par_err_sts_o, 0);
      tick();
      chk("R9 pulse end", nmi_o | smi_o, 0);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule